// File: doc/BRIEF.md
# Link Speed Upgrade Sequencer

This block brings a serial link up in two stages. It first caps the link at first-generation speed by a read-modify-write of a 4-bit max-speed field and only then enables link training. Once the external training logic reports link-up, and if the caller asked for second-generation speed, it raises the cap to 2. It then requests a directed speed change by setting bit 17 of a speed-control register and waits for that bit to self-clear. Finally it checks that the link is still up and reads back the negotiated speed.

All register traffic goes through a simple request/acknowledge master port, one access at a time. The training state machine and the register file sit outside the block. A variant selector chooses whether the self-clear poll is governed by an input, always run or always skipped. The skip covers link partners whose speed-change bit stays set when no speed transition happens. Any failed step ends the run with a sticky error and a one-cycle receiver-reset request toward the PHY.

Top module: `link_speed_seq`

## Requirements
- R1: After an accepted start, the block reads the cap register and writes it back with bits [3:0] = 1 and every other bit unchanged, before any other write.
- R2: `train_en` rises only in the cycle after the cap write (bits [3:0] = 1) is acknowledged, and stays low until then.
- R3: When `tgt_gen` was 2 at start and the link is up, the cap register is rewritten with bits [3:0] = 2 (other bits kept), then the speed-control register is rewritten with bit 17 set (other bits kept). For any other `tgt_gen` value, neither write happens.
- R4: After the speed-change write, the speed-control register is read until bit 17 reads 0. There are at most POLL_TRIES reads, consecutive reads are at least POLL_GAP_CYC+1 cycles apart, and a bit still set on the last read is a failure.
- R5: With SKIP_SRC = 0, `skip_poll` = 1 at start removes the poll entirely. SKIP_SRC = 1 always polls and SKIP_SRC = 2 never polls.
- R6: After the speed change, link-up is confirmed again, with the same timeout, before success. Loss of the link there is a failure.
- R7: On success, `neg_speed` holds bits [19:16] of the link status register, read as the last access of the run.
- R8: Every failure produces exactly one one-cycle `phy_rx_rst_req` pulse, sets `error` and drops `train_en` in the same cycle.
- R9: If the link is not up within LINK_WAIT_CYC cycles of training being enabled, the run fails and returns to idle.
- R10: `done` is a one-cycle pulse and is never high together with `error`. `error` stays high until the next accepted start, which clears it at the following edge.
- R11: `start` is ignored while a run is in progress. `tgt_gen` and `skip_poll` are sampled only when a start is accepted.
- R12: `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` stay stable from request until the cycle of `reg_ack`, and only one access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| tgt_gen | input | 2 | Target generation; 2 requests the upgrade |
| skip_poll | input | 1 | Skip the self-clear poll (when SKIP_SRC = 0) |
| link_up | input | 1 | Link-up indication from the training logic |
| train_en | output | 1 | Link training enable |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | AW | Register address |
| reg_wdata | output | DW | Write data |
| reg_rdata | input | DW | Read data, valid with `reg_ack` |
| reg_ack | input | 1 | One-cycle access acknowledge |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | Sticky failure flag |
| neg_speed | output | 4 | Negotiated speed read at success |
| phy_rx_rst_req | output | 1 | One-cycle PHY receiver reset request on failure |

## Verification
The assertions assume that `reg_ack` is a single-cycle pulse and comes only while `reg_req` is high, with `reg_rdata` valid in that same cycle. They also assume `start` is a one-cycle pulse. The bench register model meets these conditions: it acknowledges exactly one cycle after it sees a request and never acknowledges on its own. The link model raises `link_up` only while `train_en` is high, after a chosen delay. It can also withhold link-up entirely, drop the link when the speed-change request lands, or leave bit 17 set for a chosen number of reads.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CAP_RD,
      S_CAP_WR,
      S_LINK,
      S_UP_RD,
      S_UP_WR,
      S_CHG_RD,
      S_CHG_WR,
      S_POLL_RD,
      S_GAP,
      S_CONFIRM,
      S_STAT_RD,
      S_FAIL
   } lss_state_e;

   localparam int SPD_FIELD_W = 4;

   function automatic logic is_access(lss_state_e s);
      return (s == S_CAP_RD) || (s == S_CAP_WR) || (s == S_UP_RD) ||
             (s == S_UP_WR)  || (s == S_CHG_RD) || (s == S_CHG_WR) ||
             (s == S_POLL_RD) || (s == S_STAT_RD);
   endfunction

   function automatic logic is_write(lss_state_e s);
      return (s == S_CAP_WR) || (s == S_UP_WR) || (s == S_CHG_WR);
   endfunction

endpackage

// File: rtl/lss_timer.sv
module lss_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic hit
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("lss_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (en)      cnt <= cnt + 1'b1;
   end

   assign hit = en && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/lss_bus_master.sv
module lss_bus_master #(
   parameter int AW = 12,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          go_we,
   input  logic [AW-1:0] go_addr,
   input  logic [DW-1:0] go_wdata,
   output logic          busy,
   output logic          fin,
   output logic          reg_req,
   output logic          reg_we,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   input  logic          reg_ack
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         reg_we    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
      end else if (go && !busy) begin
         busy      <= 1'b1;
         reg_we    <= go_we;
         reg_addr  <= go_addr;
         reg_wdata <= go_wdata;
      end else if (busy && reg_ack) begin
         busy      <= 1'b0;
      end
   end

   assign reg_req = busy;
   assign fin     = busy && reg_ack;

   // R12: request fields hold until acknowledged
   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) &&
                                 $stable(reg_wdata) && $stable(reg_we)));

   // R12: a finished access leaves the port idle for a cycle
   p_one_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_ack) |=> !reg_req);

endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
   import lss_pkg::*;
#(
   parameter int          AW            = 12,
   parameter int          DW            = 32,
   parameter logic [11:0] CAP_ADDR      = 12'h010,
   parameter logic [11:0] SPD_ADDR      = 12'h014,
   parameter logic [11:0] STAT_ADDR     = 12'h018,
   parameter int          CHG_BIT       = 17,
   parameter int          STAT_LSB      = 16,
   parameter int          LINK_WAIT_CYC = 4096,
   parameter int          POLL_TRIES    = 200,
   parameter int          POLL_GAP_CYC  = 256,
   parameter int          SKIP_SRC      = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [1:0]             tgt_gen,
   input  logic                   skip_poll,
   input  logic                   link_up,
   output logic                   train_en,
   output logic                   reg_req,
   output logic                   reg_we,
   output logic [AW-1:0]          reg_addr,
   output logic [DW-1:0]          reg_wdata,
   input  logic [DW-1:0]          reg_rdata,
   input  logic                   reg_ack,
   output logic                   done,
   output logic                   error,
   output logic [SPD_FIELD_W-1:0] neg_speed,
   output logic                   phy_rx_rst_req
);

   localparam int TW = (POLL_TRIES < 2) ? 1 : $clog2(POLL_TRIES + 1);
   localparam logic [DW-1:0] CHG_MASK = {{(DW-1){1'b0}}, 1'b1} << CHG_BIT;
   localparam logic [AW-1:0] A_CAP  = AW'(CAP_ADDR);
   localparam logic [AW-1:0] A_SPD  = AW'(SPD_ADDR);
   localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);
   localparam logic [SPD_FIELD_W-1:0] GEN1 = SPD_FIELD_W'(1);
   localparam logic [SPD_FIELD_W-1:0] GEN2 = SPD_FIELD_W'(2);

   generate
      if (DW < STAT_LSB + SPD_FIELD_W) begin : g_bad_stat
         $error("link_speed_seq: status field beyond data width");
      end
      if (CHG_BIT < SPD_FIELD_W || CHG_BIT >= DW) begin : g_bad_chg
         $error("link_speed_seq: CHG_BIT out of range");
      end
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("link_speed_seq: AW must be 1..12");
      end
      if (POLL_TRIES < 1 || POLL_GAP_CYC < 1 || LINK_WAIT_CYC < 1) begin : g_bad_cnt
         $error("link_speed_seq: counts must be at least 1");
      end
      if (SKIP_SRC < 0 || SKIP_SRC > 2) begin : g_bad_skip
         $error("link_speed_seq: SKIP_SRC must be 0, 1 or 2");
      end
   endgenerate

   lss_state_e    state;
   logic          tgt2_q;
   logic          skip_q;
   logic          skip_eff;
   logic [TW-1:0] tries;
   logic [DW-1:0] rd_q;

   logic          go, go_we, busy, fin;
   logic [AW-1:0] go_addr;
   logic [DW-1:0] go_wdata;

   logic          link_wait, link_hit, gap_hit;

   // variant selection for the self-clear poll
   generate
      if (SKIP_SRC == 0) begin : g_skip_pin
         assign skip_eff = skip_q;
      end else if (SKIP_SRC == 1) begin : g_skip_never
         assign skip_eff = 1'b0;
      end else begin : g_skip_always
         assign skip_eff = 1'b1;
      end
   endgenerate

   // access command decode
   assign go    = is_access(state) && !busy;
   assign go_we = is_write(state);

   always_comb begin
      go_addr  = A_CAP;
      go_wdata = '0;
      case (state)
         S_CAP_WR:  go_wdata = {rd_q[DW-1:SPD_FIELD_W], GEN1};
         S_UP_WR:   go_wdata = {rd_q[DW-1:SPD_FIELD_W], GEN2};
         S_CHG_RD,
         S_POLL_RD: go_addr  = A_SPD;
         S_CHG_WR: begin
            go_addr  = A_SPD;
            go_wdata = rd_q | CHG_MASK;
         end
         S_STAT_RD: go_addr  = A_STAT;
         default:   go_addr  = A_CAP;
      endcase
   end

   lss_bus_master #(.AW(AW), .DW(DW)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .go_we     (go_we),
      .go_addr   (go_addr),
      .go_wdata  (go_wdata),
      .busy      (busy),
      .fin       (fin),
      .reg_req   (reg_req),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_ack   (reg_ack)
   );

   assign link_wait = (state == S_LINK) || (state == S_CONFIRM);

   lss_timer #(.LIMIT(LINK_WAIT_CYC)) u_link_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!link_wait),
      .en    (link_wait && !link_up),
      .hit   (link_hit)
   );

   lss_timer #(.LIMIT(POLL_GAP_CYC)) u_gap_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state != S_GAP),
      .en    (state == S_GAP),
      .hit   (gap_hit)
   );

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= S_IDLE;
         tgt2_q         <= 1'b0;
         skip_q         <= 1'b0;
         tries          <= '0;
         rd_q           <= '0;
         train_en       <= 1'b0;
         done           <= 1'b0;
         error          <= 1'b0;
         neg_speed      <= '0;
         phy_rx_rst_req <= 1'b0;
      end else begin
         done           <= 1'b0;
         phy_rx_rst_req <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               state    <= S_CAP_RD;
               tgt2_q   <= (tgt_gen == 2'd2);
               skip_q   <= skip_poll;
               tries    <= '0;
               error    <= 1'b0;
               train_en <= 1'b0;
            end
            S_CAP_RD: if (fin) begin
               rd_q  <= reg_rdata;
               state <= S_CAP_WR;
            end
            S_CAP_WR: if (fin) begin
               train_en <= 1'b1;
               state    <= S_LINK;
            end
            S_LINK: begin
               if (link_up)       state <= tgt2_q ? S_UP_RD : S_STAT_RD;
               else if (link_hit) state <= S_FAIL;
            end
            S_UP_RD: if (fin) begin
               rd_q  <= reg_rdata;
               state <= S_UP_WR;
            end
            S_UP_WR: if (fin) state <= S_CHG_RD;
            S_CHG_RD: if (fin) begin
               rd_q  <= reg_rdata;
               state <= S_CHG_WR;
            end
            S_CHG_WR: if (fin) state <= skip_eff ? S_CONFIRM : S_POLL_RD;
            S_POLL_RD: if (fin) begin
               if (!reg_rdata[CHG_BIT])             state <= S_CONFIRM;
               else if (tries == TW'(POLL_TRIES-1)) state <= S_FAIL;
               else begin
                  tries <= tries + 1'b1;
                  state <= S_GAP;
               end
            end
            S_GAP: if (gap_hit) state <= S_POLL_RD;
            S_CONFIRM: begin
               if (link_up)       state <= S_STAT_RD;
               else if (link_hit) state <= S_FAIL;
            end
            S_STAT_RD: if (fin) begin
               neg_speed <= reg_rdata[STAT_LSB +: SPD_FIELD_W];
               done      <= 1'b1;
               state     <= S_IDLE;
            end
            S_FAIL: begin
               error          <= 1'b1;
               phy_rx_rst_req <= 1'b1;
               train_en       <= 1'b0;
               state          <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R2: training turns on only after a gen1 cap write was acknowledged
   p_train_after_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(train_en) |-> $past(reg_ack && reg_we && reg_addr == A_CAP &&
                                reg_wdata[SPD_FIELD_W-1:0] == GEN1));

   // R10: done lasts one cycle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: error is sticky until a new start
   p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !start) |=> error);

   // R10: success and failure are exclusive
   p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !error);

   // R8: reset request comes with error and training off
   p_rst_with_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rx_rst_req |-> (error && !train_en));

   // R7: reported speed is the field of the final status read
   p_speed_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(reg_ack && !reg_we && reg_addr == A_STAT) &&
                neg_speed == $past(reg_rdata[STAT_LSB +: SPD_FIELD_W])));

   // R3: a speed-change request is only written while the link is up
   p_chg_with_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_we && reg_addr == A_SPD) |-> train_en);

endmodule

// File: tb/link_speed_seq_tb.sv
module link_speed_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam logic [11:0] A_CAP = 12'h010;
   localparam logic [11:0] A_SPD = 12'h014;
   localparam logic [11:0] A_ST  = 12'h018;
   localparam int LWAIT = 40;
   localparam int TRIES = 5;
   localparam int GAP   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, skip_poll = 1'b0, new_run = 1'b0;
   logic [1:0] tgt_gen = 2'd1;
   logic link_up, train_en, reg_req, reg_we, reg_ack, done, error, phy_rx_rst_req;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata, reg_rdata;
   logic [3:0] neg_speed;

   always #(CLK_PERIOD/2) clk = ~clk;

   link_speed_seq #(.AW(AW), .DW(DW), .CAP_ADDR(A_CAP), .SPD_ADDR(A_SPD),
      .STAT_ADDR(A_ST), .LINK_WAIT_CYC(LWAIT), .POLL_TRIES(TRIES),
      .POLL_GAP_CYC(GAP), .SKIP_SRC(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tgt_gen(tgt_gen),
      .skip_poll(skip_poll), .link_up(link_up), .train_en(train_en),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
      .done(done), .error(error), .neg_speed(neg_speed),
      .phy_rx_rst_req(phy_rx_rst_req));

   // scenario configuration (driven by tasks only)
   int cfg_link_delay = 10;   // -1: never
   int cfg_clr_after  = 0;    // reads returning bit 17 set after request
   bit cfg_drop       = 1'b0;
   localparam logic [31:0] CAP_INIT = 32'hABC0_0123;
   localparam logic [31:0] SPD_INIT = 32'h0000_0040;

   // behavioural environment and reference observations
   logic [31:0] cap_r, spd_r;
   logic [3:0]  cur_speed;
   bit          pend, drop_now;
   int          preads, spd_reads, lcnt, done_cnt, rst_cnt, train_cyc;
   int          cyc, last_poll, min_gap, v_req, v_done, v_train;
   logic [43:0] wlog[$];
   logic        p_req, p_done, p_ack;
   logic [AW-1:0] p_addr;
   logic [DW-1:0] p_wdata;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         reg_ack <= 1'b0; reg_rdata <= '0; link_up <= 1'b0;
         cap_r <= CAP_INIT; spd_r <= SPD_INIT; cur_speed <= 4'd1;
         pend <= 1'b0; drop_now <= 1'b0; preads <= 0; spd_reads <= 0;
         lcnt <= 0; done_cnt <= 0; rst_cnt <= 0; train_cyc <= 0;
         last_poll <= -1000; min_gap <= 1000;
         v_req <= 0; v_done <= 0; v_train <= 0;
         p_req <= 1'b0; p_done <= 1'b0; p_ack <= 1'b0;
         p_addr <= '0; p_wdata <= '0;
      end else begin
         // per-clock reference checks
         if (p_req && !p_ack && (!reg_req || reg_addr != p_addr || reg_wdata != p_wdata))
            v_req <= v_req + 1;
         if (p_done && done) v_done <= v_done + 1;
         if (train_en && cap_r[3:0] != 4'd1 && cap_r[3:0] != 4'd2) v_train <= v_train + 1;
         p_req <= reg_req; p_ack <= reg_ack; p_done <= done;
         p_addr <= reg_addr; p_wdata <= reg_wdata;
         if (done) done_cnt <= done_cnt + 1;
         if (phy_rx_rst_req) rst_cnt <= rst_cnt + 1;
         if (train_en) train_cyc <= train_cyc + 1;
         // link model
         if (!train_en) begin
            link_up <= 1'b0; lcnt <= 0;
         end else begin
            lcnt <= lcnt + 1;
            if (drop_now) link_up <= 1'b0;
            else if (cfg_link_delay >= 0 && lcnt >= cfg_link_delay) link_up <= 1'b1;
         end
         // register model: acknowledge one cycle after request
         reg_ack <= 1'b0;
         if (reg_req && !reg_ack) begin
            reg_ack <= 1'b1;
            if (reg_we) begin
               wlog.push_back({reg_addr, reg_wdata});
               if (reg_addr == A_CAP) cap_r <= reg_wdata;
               if (reg_addr == A_SPD) begin
                  spd_r <= reg_wdata;
                  if (reg_wdata[17]) begin
                     pend <= 1'b1; preads <= 0; cur_speed <= 4'd2;
                     if (cfg_drop) drop_now <= 1'b1;
                  end
               end
            end else begin
               if (reg_addr == A_CAP) reg_rdata <= cap_r;
               else if (reg_addr == A_ST) reg_rdata <= {12'h5A5, cur_speed, 16'h1234};
               else if (reg_addr == A_SPD) begin
                  if (pend) begin
                     spd_reads <= spd_reads + 1;
                     if (cyc - last_poll < min_gap) min_gap <= cyc - last_poll;
                     last_poll <= cyc;
                     if (preads < cfg_clr_after) begin
                        reg_rdata <= spd_r; preads <= preads + 1;
                     end else begin
                        reg_rdata <= spd_r & ~32'h0002_0000;
                        spd_r[17] <= 1'b0; pend <= 1'b0;
                     end
                  end else reg_rdata <= spd_r;
               end else reg_rdata <= '0;
            end
         end
         if (new_run) begin
            wlog.delete(); cap_r <= CAP_INIT; spd_r <= SPD_INIT; cur_speed <= 4'd1;
            pend <= 1'b0; drop_now <= 1'b0; spd_reads <= 0; done_cnt <= 0;
            rst_cnt <= 0; train_cyc <= 0; last_poll <= -1000; min_gap <= 1000;
         end
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic eq(input string tag, input longint act, input longint exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic kick(input logic [1:0] g, input logic sk);
      @(negedge clk);
      start = 1'b1; new_run = 1'b1; tgt_gen = g; skip_poll = sk;
      @(negedge clk);
      start = 1'b0; new_run = 1'b0;
   endtask

   task automatic finish_wait();
      int k;
      k = 0;
      while (done_cnt == 0 && !error && k < 5000) begin
         @(negedge clk); k++;
      end
      chk(k < 5000, "R9 run finished", k, 0);
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [43:0] w(input logic [11:0] a, input logic [31:0] d);
      return {a, d};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      eq("R10 reset done", done, 0);
      eq("R10 reset error", error, 0);
      eq("R2 reset train_en", train_en, 0);
      eq("R12 reset reg_req", reg_req, 0);
      eq("R8 reset phy_rx_rst_req", phy_rx_rst_req, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // gen1 only
      cfg_link_delay = 10; cfg_clr_after = 0; cfg_drop = 0;
      kick(2'd1, 1'b0);
      finish_wait();
      eq("R10 gen1 done pulses", done_cnt, 1);
      eq("R10 gen1 error", error, 0);
      eq("R1 gen1 write count", wlog.size(), 1);
      if (wlog.size() > 0) eq("R1 gen1 cap write", wlog[0], w(A_CAP, 32'hABC0_0121));
      eq("R7 gen1 speed", neg_speed, 1);
      eq("R2 gen1 train_en held", train_en, 1);
      eq("R3 gen1 no speed-change write", spd_reads, 0);

      // gen2, bit clears after three reads
      cfg_clr_after = 3;
      kick(2'd2, 1'b0);
      finish_wait();
      eq("R3 gen2 write count", wlog.size(), 3);
      if (wlog.size() == 3) begin
         eq("R1 gen2 first write", wlog[0], w(A_CAP, 32'hABC0_0121));
         eq("R3 gen2 cap raise", wlog[1], w(A_CAP, 32'hABC0_0122));
         eq("R3 gen2 speed change", wlog[2], w(A_SPD, 32'h0002_0040));
      end
      eq("R4 poll reads until clear", spd_reads, 4);
      chk(min_gap >= GAP + 1, "R4 poll spacing", min_gap, GAP + 1);
      eq("R6 gen2 done pulses", done_cnt, 1);
      eq("R7 gen2 speed", neg_speed, 2);

      // gen2, bit never clears, poll enabled
      cfg_clr_after = 1000;
      kick(2'd2, 1'b0);
      finish_wait();
      eq("R4 poll timeout error", error, 1);
      eq("R4 poll read limit", spd_reads, TRIES);
      eq("R8 reset request pulses", rst_cnt, 1);
      eq("R8 train_en dropped", train_en, 0);
      eq("R10 no done on failure", done_cnt, 0);

      // next start clears error; skip variant
      kick(2'd2, 1'b1);
      eq("R10 error cleared by start", error, 0);
      finish_wait();
      eq("R5 skip done pulses", done_cnt, 1);
      eq("R5 skip no poll reads", spd_reads, 0);
      eq("R5 skip speed", neg_speed, 2);
      eq("R5 skip write count", wlog.size(), 3);

      // link never comes up
      cfg_link_delay = -1;
      kick(2'd2, 1'b0);
      finish_wait();
      eq("R9 link timeout error", error, 1);
      chk(train_cyc >= LWAIT && train_cyc <= LWAIT + 3, "R9 timeout length", train_cyc, LWAIT);
      eq("R9 only cap written", wlog.size(), 1);
      eq("R8 link fail reset pulse", rst_cnt, 1);

      // link lost during speed change
      cfg_link_delay = 5; cfg_clr_after = 0; cfg_drop = 1;
      kick(2'd2, 1'b0);
      finish_wait();
      eq("R6 confirm loss error", error, 1);
      eq("R6 no done", done_cnt, 0);
      eq("R8 confirm fail reset pulse", rst_cnt, 1);

      // start while busy is ignored; target sampled at accepted start
      cfg_drop = 0; cfg_link_delay = 10;
      kick(2'd1, 1'b0);
      repeat (4) @(negedge clk);
      start = 1'b1; tgt_gen = 2'd2;
      @(negedge clk);
      start = 1'b0;
      finish_wait();
      eq("R11 single run writes", wlog.size(), 1);
      eq("R11 done pulses", done_cnt, 1);
      eq("R11 speed stays gen1", neg_speed, 1);

      // per-clock reference violations
      eq("R12 request stability", v_req, 0);
      eq("R10 done single cycle", v_done, 0);
      eq("R2 train only with capped field", v_train, 0);

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired actual=0x1 expected=0x0");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule